// File: doc/BRIEF.md
# Serial Peripheral Master with Slave-Ready Handshake

This block is an SPI master for a single slave. It sends one 8-bit command word and then reads back a programmed number of 8-bit response words. It does not rely only on fixed waits. Before each response word it waits on an active-low ready line driven by the slave. A timeout counter ends the transfer if the slave never becomes ready.

The host starts a transfer with a one-cycle `start` pulse and gives the command word and the response count. The configuration inputs must be held stable while `busy` is high. They set the following:

- the SCLK half period, counted in system clocks;
- three idle gaps: before the first SCLK edge, between the command and the response, and after the last SCLK edge;
- the ready timeout;
- the SCLK idle level;
- the bit order;
- the MISO sampling edge;
- the select polarity.

Each received word is presented on `rx_word` together with a one-cycle `rx_valid` strobe.

Within a bit, MOSI changes at the start of the bit and SCLK stays at its idle level for the first half. The SCLK transition into the active level is the leading edge. The transition back to idle, at the end of the bit, is the trailing edge.

Top module: `spi_ready_master`

## Requirements
- R1: During reset and while idle, `busy`, `done`, `rx_valid` and `timeout_err` are 0, `sclk` equals `cfg_cpol`, and `mosi` is 0.
- R2: The select becomes active in the cycle after `start` is sampled while idle. It stays active for `cfg_pre`+1 clocks before the command's first bit period begins.
- R3: While shifting, each SCLK half period lasts `cfg_div` system clocks (`cfg_div` ≥ 1). Outside the bit periods, SCLK rests at `cfg_cpol`.
- R4: The command is driven on MOSI one bit per SCLK period. Bit 7 goes first when `cfg_lsb_first`=0 and bit 0 goes first when it is 1. MOSI is 0 during response words.
- R5: MISO is sampled on the leading edge when `cfg_late_sample`=0 and on the trailing edge when it is 1. The received bits are placed in the same order that `cfg_lsb_first` selects.
- R6: After the command's final trailing edge, the master waits `cfg_gap`+1 clocks before it first samples `ready_n`.
- R7: No response word starts unless `ready_n` was sampled low in the preceding clock. The ready check is repeated before every response word.
- R8: If `ready_n` is sampled high on `cfg_timeout`+1 consecutive clocks of a ready wait, the following happens:
  - the transfer aborts;
  - the select returns inactive;
  - `timeout_err` is set and `done` pulses.

  `timeout_err` stays set until the next `start`.
- R9: After each response word's final trailing edge, `rx_valid` is high for exactly one clock, with the word on `rx_word`.
- R10: After the final trailing edge of the transfer, the select stays active for `cfg_post`+1 clocks. It then goes inactive in the same cycle that `done` pulses.
- R11: With `resp_words`=0, only the command is sent: no gap, no ready wait, no `rx_valid`.
- R12: The select is active-high when `cfg_sel_high`=1 and active-low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| cmd_word | input | 8 | Command word to transmit |
| resp_words | input | 8 | Number of response words, 0 to 255 |
| cfg_div | input | DIV_W | SCLK half period in system clocks |
| cfg_pre | input | GAP_W | Idle gap before the first SCLK edge |
| cfg_gap | input | GAP_W | Gap between command and response |
| cfg_post | input | GAP_W | Idle gap after the last SCLK edge |
| cfg_timeout | input | TO_W | Ready-wait limit in system clocks |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_late_sample | input | 1 | 1: sample MISO on trailing edge |
| cfg_sel_high | input | 1 | 1: select active-high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| sel | output | 1 | Slave select |
| ready_n | input | 1 | Slave ready, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout_err | output | 1 | Ready wait timed out |
| rx_word | output | 8 | Last received response word |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |

## Verification
The embedded assertions check the following properties on every cycle:
- a response word begins only after a low sample of `ready_n`;
- the select rests at its inactive level when idle;
- SCLK is back at its idle level when a transfer ends;
- `rx_valid` never lasts two cycles;
- `timeout_err` rises only out of a ready wait with `ready_n` high;
- `done` coincides with idle.

The exact placement of each gap, the half-period lengths, the bit order on MOSI and the sampling edge for MISO are shown only by the bench. Its behavioural model predicts every output on every clock. The bench exercises:
- both polarities;
- both bit orders and both sampling edges;
- several dividers;
- a slave whose ready line toggles;
- a zero-length response;
- a timeout followed by a clean transfer.

// File: rtl/spi_ready_master.sv
module spi_ready_master #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd_word,
  input  logic [7:0]       resp_words,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [GAP_W-1:0] cfg_pre,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [GAP_W-1:0] cfg_post,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic             cfg_cpol,
  input  logic             cfg_lsb_first,
  input  logic             cfg_late_sample,
  input  logic             cfg_sel_high,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             sel,
  input  logic             ready_n,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [7:0]       rx_word,
  output logic             rx_valid
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CMD, S_GAP, S_RDY, S_RESP, S_POST} st_t;
  st_t st;

  logic [7:0]       cmd_q, left_q, rx_q, rx_next;
  logic [2:0]       bit_q;
  logic             half_q;
  logic [DIV_W-1:0] div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [TO_W-1:0]  to_cnt;

  wire       shifting = (st == S_CMD) || (st == S_RESP);
  wire [2:0] idx      = cfg_lsb_first ? bit_q : 3'd7 - bit_q;
  wire       half_end = div_cnt == cfg_div - 1'b1;
  wire       word_end = shifting && half_end && half_q && (bit_q == 3'd7);
  wire       capture  = shifting && half_end && (half_q == cfg_late_sample);

  assign sclk = cfg_cpol ^ (shifting && half_q);
  assign mosi = (st == S_CMD) && cmd_q[idx];
  assign sel  = (st != S_IDLE) ~^ cfg_sel_high;
  assign busy = st != S_IDLE;

  always_comb begin
    rx_next = rx_q;
    if (capture) rx_next[idx] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_q <= '0; left_q <= '0; rx_q <= '0; rx_word <= '0;
      bit_q <= '0; half_q <= 1'b0; div_cnt <= '0; gap_cnt <= '0; to_cnt <= '0;
      done <= 1'b0; rx_valid <= 1'b0; timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      rx_valid <= 1'b0;
      if (shifting) begin
        rx_q <= rx_next;
        if (half_end) begin
          div_cnt <= '0;
          half_q  <= ~half_q;
          if (half_q) bit_q <= bit_q + 3'd1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_PRE; cmd_q <= cmd_word; left_q <= resp_words;
          gap_cnt <= '0; timeout_err <= 1'b0;
        end
        S_PRE: if (gap_cnt == cfg_pre) begin
          st <= S_CMD; div_cnt <= '0; half_q <= 1'b0; bit_q <= '0;
        end else gap_cnt <= gap_cnt + 1'b1;
        S_CMD: if (word_end) begin
          gap_cnt <= '0;
          st <= (left_q == 8'd0) ? S_POST : S_GAP;
        end
        S_GAP: if (gap_cnt == cfg_gap) begin
          st <= S_RDY; to_cnt <= '0;
        end else gap_cnt <= gap_cnt + 1'b1;
        S_RDY: if (!ready_n) begin
          st <= S_RESP; div_cnt <= '0; half_q <= 1'b0; bit_q <= '0;
        end else if (to_cnt == cfg_timeout) begin
          st <= S_IDLE; timeout_err <= 1'b1; done <= 1'b1;
        end else to_cnt <= to_cnt + 1'b1;
        S_RESP: if (word_end) begin
          rx_valid <= 1'b1; rx_word <= rx_next;
          left_q <= left_q - 8'd1; gap_cnt <= '0; to_cnt <= '0;
          st <= (left_q == 8'd1) ? S_POST : S_RDY;
        end
        S_POST: if (gap_cnt == cfg_post) begin
          st <= S_IDLE; done <= 1'b1;
        end else gap_cnt <= gap_cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP && $past(st) == S_RDY) |-> !$past(ready_n));
  assert_sel_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel == !cfg_sel_high));
  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(sclk) == cfg_cpol));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(st == S_RDY && ready_n));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_spi_ready_master.sv
module tb_spi_ready_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'hB5E3_1C96;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd_word = '0, resp_words = '0;
  logic [7:0] cfg_div = 8'd1, cfg_pre = '0, cfg_gap = '0, cfg_post = '0;
  logic [15:0] cfg_timeout = 16'd50;
  logic cfg_cpol = 0, cfg_lsb_first = 0, cfg_late_sample = 0, cfg_sel_high = 0;
  logic sclk, mosi, miso, sel, busy, done, timeout_err, rx_valid;
  logic ready_n = 1'b0;
  logic [7:0] rx_word;

  int checks = 0, failures = 0, rmode = 0, rcnt = 0, k = 0, nvalid = 0, cycles = 0;
  logic prev_sclk = 1'b0;

  spi_ready_master dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state: values expected after each edge
  logic m_busy = 0, m_sel = 0, m_sclk = 0, m_mosi = 0, m_rxv = 0, m_done = 0, m_err = 0;
  logic [7:0] m_rxd = '0, m_rx = '0;

  task automatic tick();
    @(posedge clk);
    m_rxv = 0; m_done = 0;
  endtask

  task automatic m_shift(input logic [7:0] w, input bit is_cmd);
    for (int b = 0; b < 8; b++) begin
      int ix;
      ix = cfg_lsb_first ? b : 7 - b;
      m_mosi = is_cmd ? w[ix] : 1'b0;
      m_sclk = 0;
      repeat (cfg_div) tick();
      if (!cfg_late_sample) m_rx[ix] = miso;
      m_sclk = 1;
      repeat (cfg_div) tick();
      if (cfg_late_sample) m_rx[ix] = miso;
      m_sclk = 0; m_mosi = 0;
    end
  endtask

  task automatic m_run();
    logic [7:0] lcmd, lcnt;
    int t;
    lcmd = cmd_word; lcnt = resp_words;
    m_busy = 1; m_sel = 1; m_err = 0;
    repeat (cfg_pre + 1) tick();
    m_shift(lcmd, 1);
    if (lcnt != 0) begin
      repeat (cfg_gap + 1) tick();
      for (int w = 0; w < lcnt; w++) begin
        t = 0;
        forever begin
          tick();
          if (!ready_n) break;
          if (t == cfg_timeout) begin
            m_busy = 0; m_sel = 0; m_err = 1; m_done = 1;
            return;
          end
          t++;
        end
        m_shift(8'h00, 0);
        m_rxv = 1; m_rxd = m_rx;
      end
    end
    repeat (cfg_post + 1) tick();
    m_busy = 0; m_sel = 0; m_done = 1;
  endtask

  initial forever begin
    tick();
    if (rst_n && start && !m_busy) m_run();
  end

  // slave: ready pattern and MISO stream, all changes at negedge
  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    ready_n <= (rmode == 0) ? 1'b0 : (rmode == 1) ? 1'b1 : ((rcnt % 7) < 3);
    if (!busy) begin
      k = 0;
    end else if (sclk != prev_sclk) begin
      if ((sclk != cfg_cpol) == cfg_late_sample) k = k + 1;
    end
    prev_sclk <= sclk;
    miso <= PAT[k % 32];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (rx_valid) nvalid++;
    if (rst_n) begin
      chk(busy == m_busy, "R1", "busy", busy, m_busy);
      chk(sel == (m_sel ~^ cfg_sel_high), "R2/R12", "sel", sel, m_sel ~^ cfg_sel_high);
      chk(sclk == (cfg_cpol ^ m_sclk), "R3", "sclk", sclk, cfg_cpol ^ m_sclk);
      chk(mosi == m_mosi, "R4", "mosi", mosi, m_mosi);
      chk(rx_valid == m_rxv, "R9", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_word == m_rxd, "R5", "rx_word", rx_word, m_rxd);
      chk(done == m_done, "R10", "done", done, m_done);
      chk(timeout_err == m_err, "R8", "timeout_err", timeout_err, m_err);
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic xfer(input logic [7:0] c, input logic [7:0] n);
    @(negedge clk);
    cmd_word = c; resp_words = n; nvalid = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && sclk == cfg_cpol && mosi == 0 && sel == 1, "R1", "reset outputs",
        {busy, sclk, mosi, sel}, 4'b0001);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R6: MSB first, mode 0, gaps, ready always low
    cfg_div = 2; cfg_pre = 1; cfg_gap = 3; cfg_post = 2;
    xfer(8'hA6, 8'd3);
    chk(nvalid == 3, "R9", "word count", nvalid, 3);

    // R5 R12: LSB first, idle-high clock, late sampling, active-high select, toggling ready (R7)
    cfg_div = 1; cfg_pre = 0; cfg_gap = 0; cfg_post = 0;
    cfg_cpol = 1; cfg_lsb_first = 1; cfg_late_sample = 1; cfg_sel_high = 1; rmode = 2;
    repeat (2) @(negedge clk);
    xfer(8'h3C, 8'd2);
    chk(nvalid == 2, "R7", "word count with ready waits", nvalid, 2);

    // R11: command only
    cfg_div = 3; cfg_lsb_first = 0; cfg_late_sample = 0;
    xfer(8'h81, 8'd0);
    chk(nvalid == 0, "R11", "no response words", nvalid, 0);

    // R8: ready never asserted
    rmode = 1; cfg_timeout = 5; cfg_cpol = 0; cfg_sel_high = 0;
    repeat (2) @(negedge clk);
    xfer(8'h55, 8'd1);
    chk(timeout_err == 1 && busy == 0, "R8", "abort flag", {timeout_err, busy}, 2'b10);
    chk(nvalid == 0, "R8", "no word after abort", nvalid, 0);

    // R8: flag clears on next start; R10 long post gap; R5 late sampling MSB first
    rmode = 2; cfg_timeout = 40; cfg_div = 4; cfg_post = 5; cfg_gap = 2; cfg_late_sample = 1;
    xfer(8'hF0, 8'd4);
    chk(timeout_err == 0, "R8", "flag cleared", timeout_err, 0);
    chk(nvalid == 4, "R10", "word count", nvalid, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule